// File: doc/BRIEF.md
# Floating-Point Load Fault and Deferral Decision Unit

This unit sits in the issue path of floating-point loads and, for each issued load, settles how an exceptional condition is handled. It looks at the load flavor, the deferred-exception tags on the base and increment registers, the page attribute of the access, whether the access is a 10-byte extended load, and whether the base register is post-updated. From these it chooses one of three outcomes: raise a fault, defer the exception by writing a not-a-value token into the floating-point target, or proceed normally.

Alongside that decision it computes the updated base-register value and its tag. It also emits a prefetch request for the cache line at the updated address, carrying the load's locality hint. All results leave through one registered stage, one cycle after the load is presented, marked by a valid strobe. Address translation, the memory access and the execution of the prefetch belong to other blocks.

Top module: `fpld_defer_unit`

## Requirements
- R1: Results appear on the outputs exactly one clock after `in_valid` is high. `out_valid` is high for exactly those cycles. After reset, `out_valid` is 0 and `out_fault` is 0.
- R2: Flavors are encoded on `in_flavor` as 0 normal, 1 speculative, 2 advanced, 3 speculative-advanced, 4 check-no-clear and 5 check-clear. Codes 6 and 7 count as normal. Flavors 1 and 3 are speculative and never produce a fault (`out_fault` = 0).
- R3: For a non-speculative flavor with `in_base_tag` = 1, `out_fault` is 1 (tag consumption) and `out_defer` is 0.
- R4: For a speculative flavor with `in_base_tag` = 1, `out_defer` is 1 and `out_fault` is 0.
- R5: Page attribute codes on `in_page_attr` are 0 cacheable write-back, 1 uncached, 2 write-combining and 3 tag-page. A 10-byte load (`in_ext10` = 1) to a page with code 1 or 2 is unsupported when parameter `EXT_ALL_PAGES` = 0 (the default). For a non-speculative flavor it gives `out_fault` = 2 (unsupported data reference).
- R6: An unsupported 10-byte load of a speculative flavor gives `out_defer` = 1 and `out_fault` = 0.
- R7: When both the tag-consumption fault and the unsupported fault apply, `out_fault` is 1.
- R8: With `in_base_upd` = 1 and no fault, `out_base_we` = 1 and `out_base_val` = `in_base_val` + `in_incr_val`, modulo 2^AW. `out_base_tag` is the OR of the base and increment tags. A set increment tag never causes a fault.
- R9: With `in_base_upd` = 0, `out_base_we` = 0, `out_base_val` equals `in_base_val`, and `out_pf_valid` = 0.
- R10: `out_pf_valid` is 1 exactly when `out_base_we` = 1 and `out_base_tag` = 0. In that case `out_pf_addr` is the updated base with its low `LINE_LG2` bits cleared, and `out_pf_hint` equals `in_hint`.
- R11: A faulting load has `out_base_we` = 0 and `out_pf_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A load is presented this cycle |
| in_flavor | input | 3 | Load flavor code |
| in_ext10 | input | 1 | Load is a 10-byte extended access |
| in_page_attr | input | 2 | Page attribute code |
| in_base_tag | input | 1 | Deferred-exception tag of base register |
| in_incr_tag | input | 1 | Deferred-exception tag of increment register |
| in_base_upd | input | 1 | Base-update form |
| in_base_val | input | AW | Base register value |
| in_incr_val | input | AW | Increment value |
| in_hint | input | 2 | Locality hint |
| out_valid | output | 1 | Result strobe |
| out_fault | output | 2 | 0 none, 1 tag consumption, 2 unsupported reference |
| out_defer | output | 1 | Write not-a-value token to the target |
| out_base_we | output | 1 | Write back updated base |
| out_base_val | output | AW | Updated (or unchanged) base value |
| out_base_tag | output | 1 | Tag of updated base |
| out_pf_valid | output | 1 | Prefetch request |
| out_pf_addr | output | AW | Line-aligned prefetch address |
| out_pf_hint | output | 2 | Locality hint of prefetch |

## Verification
The assertions take for granted that the input fields are meaningful only while `in_valid` is high. They compare registered outputs with the inputs of the previous cycle, so they rely on at most one load per cycle and on no hidden holding of inputs. The stimulus drives every field only on the inactive clock edge. It walks all flavors against both tag values and all page codes, with and without 10-byte size and base update. It then applies a stream of random loads with random gaps, so back-to-back and isolated loads both occur.

// File: rtl/fpld_pkg.sv
package fpld_pkg;
  typedef enum logic [2:0] {
    FLV_NORMAL   = 3'd0,
    FLV_SPEC     = 3'd1,
    FLV_ADV      = 3'd2,
    FLV_SPEC_ADV = 3'd3,
    FLV_CHK_NC   = 3'd4,
    FLV_CHK_CLR  = 3'd5
  } flavor_e;

  typedef enum logic [1:0] {
    PG_WB   = 2'd0,
    PG_UC   = 2'd1,
    PG_WC   = 2'd2,
    PG_TAGP = 2'd3
  } page_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TAGC  = 2'd1,
    FLT_UNSUP = 2'd2
  } fault_e;

  function automatic logic is_spec(input logic [2:0] f);
    return (f == FLV_SPEC) || (f == FLV_SPEC_ADV);
  endfunction
endpackage

// File: rtl/fpld_classify.sv
module fpld_classify
  import fpld_pkg::*;
#(
  parameter bit EXT_ALL_PAGES = 1'b0
) (
  input  logic [2:0] flavor,
  input  logic       ext10,
  input  logic [1:0] page_attr,
  input  logic       base_tag,
  output logic [1:0] fault,
  output logic       defer
);
  logic spec;
  logic unsup;

  assign spec = is_spec(flavor);

  generate
    if (EXT_ALL_PAGES) begin : g_ext_any
      assign unsup = 1'b0;
    end else begin : g_ext_wb
      assign unsup = ext10 && (page_attr != PG_WB) && (page_attr != PG_TAGP);
    end
  endgenerate

  always_comb begin
    fault = FLT_NONE;
    defer = 1'b0;
    if (spec) begin
      defer = base_tag || unsup;
    end else if (base_tag) begin
      fault = FLT_TAGC;
    end else if (unsup) begin
      fault = FLT_UNSUP;
    end
  end

  always_comb begin
    assert_fault_excl_defer_R3: assert (!((fault != FLT_NONE) && defer));
  end
endmodule

// File: rtl/fpld_base_upd.sv
module fpld_base_upd #(
  parameter int AW       = 32,
  parameter int LINE_LG2 = 6
) (
  input  logic          upd,
  input  logic          faulted,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] incr_val,
  input  logic          base_tag,
  input  logic          incr_tag,
  output logic          base_we,
  output logic [AW-1:0] new_base,
  output logic          new_tag,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr
);
  localparam logic [AW-1:0] LINE_MASK = ~((AW'(1) << LINE_LG2) - AW'(1));

  logic [AW-1:0] sum;

  assign sum = base_val + incr_val;

  always_comb begin
    base_we  = upd && !faulted;
    new_base = base_we ? sum : base_val;
    new_tag  = base_tag || (upd && incr_tag);
    pf_valid = base_we && !new_tag;
    pf_addr  = sum & LINE_MASK;
  end

  always_comb begin
    assert_pf_needs_update_R10: assert (!pf_valid || base_we);
  end
endmodule

// File: rtl/fpld_defer_unit.sv
module fpld_defer_unit
  import fpld_pkg::*;
#(
  parameter int AW            = 32,
  parameter int LINE_LG2      = 6,
  parameter bit EXT_ALL_PAGES = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_flavor,
  input  logic          in_ext10,
  input  logic [1:0]    in_page_attr,
  input  logic          in_base_tag,
  input  logic          in_incr_tag,
  input  logic          in_base_upd,
  input  logic [AW-1:0] in_base_val,
  input  logic [AW-1:0] in_incr_val,
  input  logic [1:0]    in_hint,
  output logic          out_valid,
  output logic [1:0]    out_fault,
  output logic          out_defer,
  output logic          out_base_we,
  output logic [AW-1:0] out_base_val,
  output logic          out_base_tag,
  output logic          out_pf_valid,
  output logic [AW-1:0] out_pf_addr,
  output logic [1:0]    out_pf_hint
);
  logic [1:0]    c_fault;
  logic          c_defer;
  logic          c_we;
  logic [AW-1:0] c_base;
  logic          c_tag;
  logic          c_pf;
  logic [AW-1:0] c_pfa;

  fpld_classify #(.EXT_ALL_PAGES(EXT_ALL_PAGES)) u_cls (
    .flavor   (in_flavor),
    .ext10    (in_ext10),
    .page_attr(in_page_attr),
    .base_tag (in_base_tag),
    .fault    (c_fault),
    .defer    (c_defer)
  );

  fpld_base_upd #(.AW(AW), .LINE_LG2(LINE_LG2)) u_upd (
    .upd     (in_base_upd),
    .faulted (c_fault != FLT_NONE),
    .base_val(in_base_val),
    .incr_val(in_incr_val),
    .base_tag(in_base_tag),
    .incr_tag(in_incr_tag),
    .base_we (c_we),
    .new_base(c_base),
    .new_tag (c_tag),
    .pf_valid(c_pf),
    .pf_addr (c_pfa)
  );

  // next-state values
  logic          n_valid;
  logic [1:0]    n_fault;
  logic          n_defer;
  logic          n_we;
  logic          n_pf;

  always_comb begin
    n_valid = in_valid;
    n_fault = in_valid ? c_fault : FLT_NONE;
    n_defer = in_valid && c_defer;
    n_we    = in_valid && c_we;
    n_pf    = in_valid && c_pf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_fault    <= FLT_NONE;
      out_defer    <= 1'b0;
      out_base_we  <= 1'b0;
      out_pf_valid <= 1'b0;
    end else begin
      out_valid    <= n_valid;
      out_fault    <= n_fault;
      out_defer    <= n_defer;
      out_base_we  <= n_we;
      out_pf_valid <= n_pf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_base_val <= '0;
      out_base_tag <= 1'b0;
      out_pf_addr  <= '0;
      out_pf_hint  <= '0;
    end else if (in_valid) begin
      out_base_val <= c_base;
      out_base_tag <= c_tag;
      out_pf_addr  <= c_pfa;
      out_pf_hint  <= in_hint;
    end
  end

  assert_spec_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(is_spec(in_flavor)) |-> out_fault == FLT_NONE);

  assert_tag_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_base_tag && !is_spec(in_flavor)) |-> out_fault == FLT_TAGC);

  assert_spec_tag_defers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_base_tag && is_spec(in_flavor)) |-> out_defer);

  assert_no_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(in_base_upd) |-> !out_base_we && !out_pf_valid);

  assert_incr_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_base_we && $past(in_incr_tag) |-> out_base_tag);

  assert_fault_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault != FLT_NONE |-> !out_base_we && !out_pf_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_fault == FLT_NONE && !out_defer && !out_pf_valid);
endmodule

// File: tb/fpld_defer_unit_tb.sv
module fpld_defer_unit_tb;
  localparam int AW = 32;
  localparam int LG = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    in_flavor = '0;
  logic          in_ext10 = 1'b0;
  logic [1:0]    in_page_attr = '0;
  logic          in_base_tag = 1'b0;
  logic          in_incr_tag = 1'b0;
  logic          in_base_upd = 1'b0;
  logic [AW-1:0] in_base_val = '0;
  logic [AW-1:0] in_incr_val = '0;
  logic [1:0]    in_hint = '0;
  logic          out_valid;
  logic [1:0]    out_fault;
  logic          out_defer;
  logic          out_base_we;
  logic [AW-1:0] out_base_val;
  logic          out_base_tag;
  logic          out_pf_valid;
  logic [AW-1:0] out_pf_addr;
  logic [1:0]    out_pf_hint;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  fpld_defer_unit #(.AW(AW), .LINE_LG2(LG)) u_dut (.*);

  // expected values for the output after the next edge
  logic          e_valid = 1'b0;
  int            e_fault = 0;
  logic          e_defer = 1'b0;
  logic          e_we = 1'b0;
  logic [AW-1:0] e_base = '0;
  logic          e_tag = 1'b0;
  logic          e_pf = 1'b0;
  logic [AW-1:0] e_pfa = '0;
  logic [1:0]    e_hint = '0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    bit spec, uns, tagf;
    spec = (in_flavor == 3'd1) || (in_flavor == 3'd3);
    uns  = in_ext10 && (in_page_attr == 2'd1 || in_page_attr == 2'd2);
    tagf = !spec && in_base_tag;
    e_valid = in_valid;
    e_fault = 0;
    e_defer = 0;
    e_we = 0;
    e_pf = 0;
    if (in_valid) begin
      if (tagf) e_fault = 1;
      else if (!spec && uns) e_fault = 2;
      e_defer = spec && (in_base_tag || uns);
      e_we = in_base_upd && (e_fault == 0);
      e_base = e_we ? in_base_val + in_incr_val : in_base_val;
      e_tag = in_base_tag || (in_base_upd && in_incr_tag);
      e_pf = e_we && !e_tag;
      e_pfa = ((in_base_val + in_incr_val) >> LG) << LG;
      e_hint = in_hint;
    end
  endtask

  task automatic compare();
    chk("R1 valid", out_valid, e_valid);
    chk("R2/R3/R5/R7 fault", out_fault, e_fault);
    chk("R4/R6 defer", out_defer, e_defer);
    chk("R8/R9/R11 base_we", out_base_we, e_we);
    chk("R10 pf_valid", out_pf_valid, e_pf);
    if (e_valid) begin
      chk("R8/R9 base_val", out_base_val, e_base);
      chk("R8 base_tag", out_base_tag, e_tag);
      if (e_pf) begin
        chk("R10 pf_addr", out_pf_addr, e_pfa);
        chk("R10 pf_hint", out_pf_hint, e_hint);
      end
    end
  endtask

  // drive at negedge, check previous result first
  task automatic step(input bit v, input int fl, input bit x, input int pg,
                      input bit bt, input bit it, input bit up,
                      input logic [AW-1:0] b, input logic [AW-1:0] inc, input int h);
    @(negedge clk);
    compare();
    in_valid = v; in_flavor = 3'(fl); in_ext10 = x; in_page_attr = 2'(pg);
    in_base_tag = bt; in_incr_tag = it; in_base_upd = up;
    in_base_val = b; in_incr_val = inc; in_hint = 2'(h);
    model();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset fault", out_fault, 0);
    rst_n = 1'b1;
    // R3 normal with base tag
    step(1, 0, 0, 0, 1, 0, 1, 32'h100, 32'h40, 1);
    // R4 speculative with base tag: defer, update with tag, no prefetch
    step(1, 1, 0, 0, 1, 0, 1, 32'h100, 32'h40, 1);
    // R5 unsupported ext on uncached, advanced
    step(1, 2, 1, 1, 0, 0, 1, 32'h200, 32'h8, 2);
    // R6 spec-advanced unsupported: defer
    step(1, 3, 1, 2, 0, 0, 1, 32'h200, 32'h8, 2);
    // R7 both faults on check-clear
    step(1, 5, 1, 1, 1, 0, 0, 32'h300, 32'h0, 0);
    // R5 ext on tag-page and write-back is fine
    step(1, 4, 1, 3, 0, 0, 1, 32'hFFFF_FFF0, 32'h20, 3);
    step(1, 0, 1, 0, 0, 0, 1, 32'h1234_5678, 32'h99, 1);
    // R8 increment tag: no fault, tag set, no prefetch
    step(1, 0, 0, 0, 0, 1, 1, 32'h1000, 32'h10, 0);
    // R9 no update
    step(1, 0, 0, 0, 0, 1, 0, 32'hABCD, 32'h77, 2);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // sweep flavors x tags x pages
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 4; p++)
        for (int t = 0; t < 4; t++)
          step(1, f, t[0], p, t[1], t[0], p[0], 32'(f * 4099 + p), 32'(t * 65), p);
    for (int i = 0; i < 2000; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 1),
           $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 3));
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule